// File: doc/BRIEF.md
# Writeback Commit, Trap and Redirect Unit

This block is the last stage of an in-order pipeline. Each cycle it may receive one retiring word: a destination register, the instruction address, two operands, a micro-op, a one-hot functional-unit select, an upstream trap flag and an instruction size. It decides whether the word writes the register file, takes a trap, returns from a trap, or sends a new fetch address. Every change of control flow leaves the pipeline from here. Jumps and branches arrive with their target and taken decision already worked out, so this stage only applies them.

The block keeps three machine registers: the trap vector base, the saved exception address and the trap cause. Exceptions found upstream arrive with the trap flag set and their cause code in operand B. Environment calls and breakpoints are detected here. A pending interrupt is taken on a valid retiring word when no synchronous exception claims that word. Any redirect raises a flush, so that the younger words held in earlier pipeline registers are discarded.

Outputs are combinational from the presented word and the machine registers. The machine registers change on the following rising clock edge.

Top module: `wb_commit_unit`

## Requirements
- R1: After a synchronous active-low reset the trap vector base reads 0x100, and the saved address and the cause read 0.
- R2: A valid word whose select is ALU (fu bit 0) or multiply (fu bit 3) writes operand A to register rd. A word with rd = 0 never produces a register-file write.
- R3: A memory word (fu bit 1) with uop 0 (load) writes operand A to rd. A memory word with uop 1 (store) writes nothing and does not redirect.
- R4: A jump word (fu bit 2) with uop 0 writes the link address to rd: pc+2 when size is 1, pc+4 otherwise. It also redirects to operand A with bit 0 cleared.
- R5: A jump word with uop 1 is a conditional branch. It redirects to operand A with bit 0 cleared only when operand B bit 0 is 1, and it never writes the register file.
- R6: A valid word with the trap flag set does not write the register file and redirects to the trap vector base. On the next edge the saved address becomes pc with bit 0 cleared and the cause becomes operand B.
- R7: A system word (fu bit 4) with uop 2 traps with cause 11, and one with uop 3 traps with cause 3. Both record pc, redirect to the trap vector base and write no register.
- R8: When irq_pending is high with a valid word that raises no synchronous exception, that word does not commit. The block redirects to the trap vector base, the saved address takes pc, and the cause takes 0x8000000B. A synchronous exception on the same word wins, and with no valid word nothing happens.
- R9: A system word with uop 4 (trap return) redirects to the current saved address and writes no register.
- R10: A system word with uop 0 reads, and with uop 1 swaps, the machine register chosen by operand B bits 1:0 (0 vector base, 1 saved address, 2 cause, 3 none, which reads 0). The old value goes to rd, and a swap stores operand A. The vector base keeps bits 1:0 at 0 and the saved address keeps bit 0 at 0.
- R11: flush is high in exactly the cycles in which redirect_valid is high.
- R12: While in_valid is low, no register write, redirect or machine-register change takes place, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A retiring word is present |
| in_rd | input | REG_W | Destination register index |
| in_pc | input | XLEN | Address of the retiring instruction |
| in_opr_a | input | XLEN | Result, load data or jump target |
| in_opr_b | input | XLEN | Cause code, branch decision or machine-register selector |
| in_uop | input | UOP_W | Micro-op within the selected unit |
| in_fu | input | FU_W | One-hot functional-unit select |
| in_trap | input | 1 | Exception raised upstream |
| in_size | input | SIZE_W | Instruction size code (1 = 16-bit) |
| irq_pending | input | 1 | Interrupt request waiting |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | REG_W | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |
| redirect_valid | output | 1 | New fetch address issued |
| redirect_pc | output | XLEN | New fetch address |
| flush | output | 1 | Discard younger words upstream |

## Verification
Stimulus covers plain results, loads and stores, 16-bit and 32-bit links, branches taken and not taken, machine-register reads and swaps, and upstream, local and interrupt traps. Writing results to rd = 0 and to a nonzero rd shows whether the zero register is protected. Sending an interrupt together with an upstream trap, with an environment call, with an ordinary word and with no valid word tests the priority order and the instruction-boundary rule. Odd jump targets and unaligned swap data show whether address bits are cleared, and trap returns issued after a trap and after a swap show which saved address the return uses.

// File: rtl/wb_pkg.sv
// Shared encodings for the writeback commit unit.
// Assumes a one-hot functional-unit select; micro-op meaning depends on the unit.
package wb_pkg;

    // Functional-unit bit positions inside the one-hot select
    localparam int FU_ALU = 0;
    localparam int FU_MEM = 1;
    localparam int FU_JMP = 2;
    localparam int FU_MUL = 3;
    localparam int FU_SYS = 4;

    // Micro-op codes, per unit
    localparam int UOP_LOAD   = 0;
    localparam int UOP_STORE  = 1;
    localparam int UOP_LINK   = 0;
    localparam int UOP_BRANCH = 1;
    localparam int UOP_CSR_RD = 0;
    localparam int UOP_CSR_SW = 1;
    localparam int UOP_ECALL  = 2;
    localparam int UOP_EBREAK = 3;
    localparam int UOP_MRET   = 4;

    // Cause codes raised locally
    localparam int CODE_BREAK   = 3;
    localparam int CODE_ECALL_M = 11;
    localparam int CODE_IRQ_EXT = 11;

    // Machine-register selector
    localparam int SEL_W     = 2;
    localparam int SEL_TVEC  = 0;
    localparam int SEL_EPC   = 1;
    localparam int SEL_CAUSE = 2;

    typedef enum logic [1:0] {
        WSRC_NONE   = 2'd0,
        WSRC_RESULT = 2'd1,
        WSRC_LINK   = 2'd2,
        WSRC_CSR    = 2'd3
    } wsrc_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TVEC = 2'd1,
        TGT_EPC  = 2'd2,
        TGT_JUMP = 2'd3
    } tgt_e;

    typedef enum logic [2:0] {
        CSRC_NONE     = 3'd0,
        CSRC_UPSTREAM = 3'd1,
        CSRC_ECALL    = 3'd2,
        CSRC_EBREAK   = 3'd3,
        CSRC_IRQ      = 3'd4
    } csrc_e;

    typedef struct packed {
        wsrc_e wsrc;
        tgt_e  tgt;
        csrc_e csrc;
        logic  csr_wr;
    } wb_plan_t;

endpackage

// File: rtl/wb_classify.sv
// Decides what the retiring word does: write source, redirect target,
// trap cause source and machine-register write.
// Assumes in_fu is one-hot. Priority: upstream trap, local exception,
// interrupt, then the normal effect of the word.
module wb_classify
    import wb_pkg::*;
#(
    parameter int FU_W  = 8,
    parameter int UOP_W = 5
)(
    input  logic             valid,
    input  logic             trap,
    input  logic [FU_W-1:0]  fu,
    input  logic [UOP_W-1:0] uop,
    input  logic             taken,
    input  logic             irq,
    output wb_plan_t         plan
);

    logic is_ecall;
    logic is_ebreak;

    assign is_ecall  = fu[FU_SYS] && (uop == UOP_W'(UOP_ECALL));
    assign is_ebreak = fu[FU_SYS] && (uop == UOP_W'(UOP_EBREAK));

    // Resolve the effect of the word in priority order
    always_comb begin : classify_word
        plan.wsrc   = WSRC_NONE;
        plan.tgt    = TGT_NONE;
        plan.csrc   = CSRC_NONE;
        plan.csr_wr = 1'b0;
        if (!valid) begin
            plan.tgt = TGT_NONE;
        end else if (trap) begin
            plan.tgt  = TGT_TVEC;
            plan.csrc = CSRC_UPSTREAM;
        end else if (is_ecall || is_ebreak) begin
            plan.tgt  = TGT_TVEC;
            plan.csrc = is_ecall ? CSRC_ECALL : CSRC_EBREAK;
        end else if (irq) begin
            plan.tgt  = TGT_TVEC;
            plan.csrc = CSRC_IRQ;
        end else if (fu[FU_SYS]) begin
            if (uop == UOP_W'(UOP_CSR_RD)) begin
                plan.wsrc = WSRC_CSR;
            end else if (uop == UOP_W'(UOP_CSR_SW)) begin
                plan.wsrc   = WSRC_CSR;
                plan.csr_wr = 1'b1;
            end else if (uop == UOP_W'(UOP_MRET)) begin
                plan.tgt = TGT_EPC;
            end
        end else if (fu[FU_JMP]) begin
            if (uop == UOP_W'(UOP_LINK)) begin
                plan.wsrc = WSRC_LINK;
                plan.tgt  = TGT_JUMP;
            end else if (uop == UOP_W'(UOP_BRANCH) && taken) begin
                plan.tgt = TGT_JUMP;
            end
        end else if (fu[FU_MEM]) begin
            if (uop == UOP_W'(UOP_LOAD)) begin
                plan.wsrc = WSRC_RESULT;
            end
        end else if (fu[FU_ALU] || fu[FU_MUL]) begin
            plan.wsrc = WSRC_RESULT;
        end
    end

endmodule

// File: rtl/wb_csr_file.sv
// Holds the trap vector base, the saved exception address and the cause.
// A trap writes address and cause; a swap writes the selected register.
// Assumes a trap and a swap never occur in the same cycle.
module wb_csr_file
    import wb_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter logic [XLEN-1:0]  TVEC_RESET = 'h100
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_take,
    input  logic [XLEN-1:0]  trap_pc,
    input  logic [XLEN-1:0]  trap_cause,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]  rd_data,
    output logic [XLEN-1:0]  tvec,
    output logic [XLEN-1:0]  epc,
    output logic [XLEN-1:0]  cause
);

    localparam int N_CSR = 3;

    logic [N_CSR-1:0][XLEN-1:0] csr_all;

    for (genvar i = 0; i < N_CSR; i++) begin : g_reg
        localparam logic [XLEN-1:0] KEEP = (i == SEL_TVEC) ? ~XLEN'(3) :
                                           (i == SEL_EPC)  ? ~XLEN'(1) :
                                                             {XLEN{1'b1}};
        localparam logic [XLEN-1:0] INIT = (i == SEL_TVEC) ? TVEC_RESET : '0;
        localparam bit TRAP_TARGET = (i != SEL_TVEC);

        logic [XLEN-1:0] q;
        logic [XLEN-1:0] trap_val;
        logic            trap_hit;
        logic            wr_hit;

        assign trap_val = (i == SEL_EPC) ? trap_pc : trap_cause;
        assign trap_hit = trap_take && TRAP_TARGET;
        assign wr_hit   = wr_en && (sel == SEL_W'(i));

        // Update one machine register on reset, trap or swap
        always_ff @(posedge clk) begin : update_csr
            if (!rst_n) begin
                q <= INIT & KEEP;
            end else if (trap_hit) begin
                q <= trap_val & KEEP;
            end else if (wr_hit) begin
                q <= wr_data & KEEP;
            end
        end

        assign csr_all[i] = q;
    end

    // Read the selected register, zero for the unused selector
    always_comb begin : read_mux
        case (sel)
            SEL_W'(SEL_TVEC):  rd_data = csr_all[SEL_TVEC];
            SEL_W'(SEL_EPC):   rd_data = csr_all[SEL_EPC];
            SEL_W'(SEL_CAUSE): rd_data = csr_all[SEL_CAUSE];
            default:           rd_data = '0;
        endcase
    end

    assign tvec  = csr_all[SEL_TVEC];
    assign epc   = csr_all[SEL_EPC];
    assign cause = csr_all[SEL_CAUSE];

endmodule

// File: rtl/wb_redirect.sv
// Picks the next fetch address from the target class of the word.
// Assumes vector base and saved address are already aligned.
module wb_redirect
    import wb_pkg::*;
#(
    parameter int XLEN = 32
)(
    input  tgt_e            tgt,
    input  logic [XLEN-1:0] tvec,
    input  logic [XLEN-1:0] epc,
    input  logic [XLEN-1:0] jump_addr,
    output logic            valid,
    output logic [XLEN-1:0] pc
);

    // Select the destination and flag a redirect
    always_comb begin : pick_target
        valid = 1'b1;
        case (tgt)
            TGT_TVEC: pc = tvec;
            TGT_EPC:  pc = epc;
            TGT_JUMP: pc = jump_addr & ~XLEN'(1);
            default: begin
                valid = 1'b0;
                pc    = '0;
            end
        endcase
    end

endmodule

// File: rtl/wb_commit_unit.sv
// Final pipeline stage: commits results, raises late exceptions, takes
// interrupts at instruction boundaries and issues every redirect and flush.
// Assumes one retiring word per cycle with no back-pressure; outputs are
// combinational, machine registers update on the next rising edge.
module wb_commit_unit
    import wb_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              REG_W      = 5,
    parameter int              UOP_W      = 5,
    parameter int              FU_W       = 8,
    parameter int              SIZE_W     = 2,
    parameter logic [XLEN-1:0] TVEC_RESET = 'h100
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [REG_W-1:0]  in_rd,
    input  logic [XLEN-1:0]   in_pc,
    input  logic [XLEN-1:0]   in_opr_a,
    input  logic [XLEN-1:0]   in_opr_b,
    input  logic [UOP_W-1:0]  in_uop,
    input  logic [FU_W-1:0]   in_fu,
    input  logic              in_trap,
    input  logic [SIZE_W-1:0] in_size,
    input  logic              irq_pending,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              flush
);

    localparam logic [XLEN-1:0] IRQ_CAUSE = {1'b1, (XLEN-1)'(CODE_IRQ_EXT)};

    wb_plan_t        plan;
    logic [XLEN-1:0] csr_rdata;
    logic [XLEN-1:0] csr_mtvec;
    logic [XLEN-1:0] csr_mepc;
    logic [XLEN-1:0] csr_mcause;
    logic [XLEN-1:0] trap_cause;
    logic [XLEN-1:0] link_addr;
    logic            trap_take;

    wb_classify #(
        .FU_W  (FU_W),
        .UOP_W (UOP_W)
    ) u_classify (
        .valid (in_valid),
        .trap  (in_trap),
        .fu    (in_fu),
        .uop   (in_uop),
        .taken (in_opr_b[0]),
        .irq   (irq_pending),
        .plan  (plan)
    );

    assign trap_take = (plan.csrc != CSRC_NONE);

    // Form the cause value for the trap being taken
    always_comb begin : cause_mux
        case (plan.csrc)
            CSRC_UPSTREAM: trap_cause = in_opr_b;
            CSRC_ECALL:    trap_cause = XLEN'(CODE_ECALL_M);
            CSRC_EBREAK:   trap_cause = XLEN'(CODE_BREAK);
            CSRC_IRQ:      trap_cause = IRQ_CAUSE;
            default:       trap_cause = '0;
        endcase
    end

    wb_csr_file #(
        .XLEN       (XLEN),
        .TVEC_RESET (TVEC_RESET)
    ) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_take  (trap_take),
        .trap_pc    (in_pc),
        .trap_cause (trap_cause),
        .wr_en      (plan.csr_wr),
        .sel        (in_opr_b[SEL_W-1:0]),
        .wr_data    (in_opr_a),
        .rd_data    (csr_rdata),
        .tvec       (csr_mtvec),
        .epc        (csr_mepc),
        .cause      (csr_mcause)
    );

    wb_redirect #(
        .XLEN (XLEN)
    ) u_redirect (
        .tgt       (plan.tgt),
        .tvec      (csr_mtvec),
        .epc       (csr_mepc),
        .jump_addr (in_opr_a),
        .valid     (redirect_valid),
        .pc        (redirect_pc)
    );

    assign link_addr = in_pc + ((in_size == SIZE_W'(1)) ? XLEN'(2) : XLEN'(4));

    // Select the register-file write data and enable
    always_comb begin : commit_mux
        case (plan.wsrc)
            WSRC_RESULT: rf_wdata = in_opr_a;
            WSRC_LINK:   rf_wdata = link_addr;
            WSRC_CSR:    rf_wdata = csr_rdata;
            default:     rf_wdata = '0;
        endcase
        rf_we    = (plan.wsrc != WSRC_NONE) && (in_rd != '0);
        rf_waddr = in_rd;
    end

    // Younger words are discarded whenever a target class is chosen
    assign flush = (plan.tgt != TGT_NONE);

endmodule

// File: rtl/wb_commit_checker.sv
// Property checker for the writeback commit unit, attached by bind.
// Assumes the internal machine-register wires of the top are visible by name.
module wb_commit_checker
    import wb_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int UOP_W = 5,
    parameter int FU_W  = 8
)(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_trap,
    input logic [FU_W-1:0]  in_fu,
    input logic [UOP_W-1:0] in_uop,
    input logic [XLEN-1:0]  in_pc,
    input logic [XLEN-1:0]  in_opr_b,
    input logic             irq_pending,
    input logic             rf_we,
    input logic [REG_W-1:0] rf_waddr,
    input logic             redirect_valid,
    input logic [XLEN-1:0]  redirect_pc,
    input logic             flush,
    input logic [XLEN-1:0]  csr_mtvec,
    input logic [XLEN-1:0]  csr_mepc,
    input logic [XLEN-1:0]  csr_mcause
);

    logic sys_exc;
    logic is_mret;

    assign sys_exc = in_fu[FU_SYS] &&
                     (in_uop == UOP_W'(UOP_ECALL) || in_uop == UOP_W'(UOP_EBREAK));
    assign is_mret = in_fu[FU_SYS] && (in_uop == UOP_W'(UOP_MRET));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!rf_we && !redirect_valid));

    assert_x0_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != '0));

    assert_trap_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_trap) |-> (!rf_we && redirect_valid && redirect_pc == csr_mtvec));

    assert_trap_saves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_trap) |=>
        (csr_mepc == ($past(in_pc) & ~XLEN'(1)) && csr_mcause == $past(in_opr_b)));

    assert_ecall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_trap && in_fu[FU_SYS] && in_uop == UOP_W'(UOP_ECALL)) |=>
        (csr_mcause == XLEN'(CODE_ECALL_M)));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && irq_pending && !in_trap && !sys_exc) |=>
        (csr_mcause == {1'b1, (XLEN-1)'(CODE_IRQ_EXT)}));

    assert_mret_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_trap && !irq_pending && is_mret) |->
        (redirect_valid && redirect_pc == csr_mepc && !rf_we));

    assert_tvec_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        csr_mtvec[1:0] == 2'b00);

    assert_flush_pairs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush == redirect_valid);

endmodule

bind wb_commit_unit wb_commit_checker #(
    .XLEN  (XLEN),
    .REG_W (REG_W),
    .UOP_W (UOP_W),
    .FU_W  (FU_W)
) u_chk (.*);

// File: tb/wb_commit_unit_bench.sv
`timescale 1ns/100ps
// Bench for the writeback commit unit: a behavioural model keeps the three
// machine registers and predicts every output of every cycle.
module wb_commit_unit_bench;

    localparam logic [7:0] F_ALU = 8'h01;
    localparam logic [7:0] F_MEM = 8'h02;
    localparam logic [7:0] F_JMP = 8'h04;
    localparam logic [7:0] F_MUL = 8'h08;
    localparam logic [7:0] F_SYS = 8'h10;
    localparam logic [31:0] IRQ_CODE = 32'h8000_000B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_rd = '0;
    logic [31:0] in_pc = '0;
    logic [31:0] in_opr_a = '0;
    logic [31:0] in_opr_b = '0;
    logic [4:0]  in_uop = '0;
    logic [7:0]  in_fu = '0;
    logic        in_trap = 1'b0;
    logic [1:0]  in_size = 2'd2;
    logic        irq_pending = 1'b0;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        flush;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_tvec, m_epc, m_cause;

    always #2.5 clk = ~clk;

    wb_commit_unit u_wb_commit_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rd(in_rd),
        .in_pc(in_pc), .in_opr_a(in_opr_a), .in_opr_b(in_opr_b),
        .in_uop(in_uop), .in_fu(in_fu), .in_trap(in_trap), .in_size(in_size),
        .irq_pending(irq_pending), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .flush(flush)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // Drive one cycle, predict the outputs, compare, then advance the model
    task automatic step(input string tag, input logic v, input logic [4:0] rd,
                        input logic [31:0] pc, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] uop,
                        input logic [7:0] fu, input logic trap,
                        input logic [1:0] size, input logic irq);
        logic we = 1'b0;
        logic [31:0] wd = '0;
        logic rv = 1'b0;
        logic [31:0] rp = '0;
        logic take = 1'b0;
        logic [31:0] cause = '0;
        logic swap = 1'b0;
        logic [31:0] old;
        @(posedge clk);
        #1;
        in_valid = v; in_rd = rd; in_pc = pc; in_opr_a = a; in_opr_b = b;
        in_uop = uop; in_fu = fu; in_trap = trap; in_size = size; irq_pending = irq;
        case (b[1:0])
            2'd0: old = m_tvec;
            2'd1: old = m_epc;
            2'd2: old = m_cause;
            default: old = 32'h0;
        endcase
        if (v) begin
            if (trap) begin take = 1; cause = b; end
            else if (fu == F_SYS && uop == 5'd2) begin take = 1; cause = 32'd11; end
            else if (fu == F_SYS && uop == 5'd3) begin take = 1; cause = 32'd3; end
            else if (irq) begin take = 1; cause = IRQ_CODE; end
            else if (fu == F_SYS) begin
                if (uop == 5'd0 || uop == 5'd1) begin we = 1; wd = old; swap = (uop == 5'd1); end
                else if (uop == 5'd4) begin rv = 1; rp = m_epc; end
            end else if (fu == F_JMP) begin
                if (uop == 5'd0) begin
                    we = 1; wd = pc + ((size == 2'd1) ? 32'd2 : 32'd4);
                    rv = 1; rp = {a[31:1], 1'b0};
                end else if (uop == 5'd1 && b[0]) begin
                    rv = 1; rp = {a[31:1], 1'b0};
                end
            end else if (fu == F_MEM) begin
                if (uop == 5'd0) begin we = 1; wd = a; end
            end else if (fu == F_ALU || fu == F_MUL) begin
                we = 1; wd = a;
            end
            if (take) begin rv = 1; rp = m_tvec; end
            if (rd == 5'd0) we = 0;
        end
        #2;
        chk(tag, "rf_we", 32'(rf_we), 32'(we));
        if (we) begin
            chk(tag, "rf_waddr", 32'(rf_waddr), 32'(rd));
            chk(tag, "rf_wdata", rf_wdata, wd);
        end
        chk(tag, "redirect_valid", 32'(redirect_valid), 32'(rv));
        if (rv) chk(tag, "redirect_pc", redirect_pc, rp);
        chk("R11", "flush", 32'(flush), 32'(rv));
        if (take) begin
            m_epc = {pc[31:1], 1'b0};
            m_cause = cause;
        end else if (swap) begin
            case (b[1:0])
                2'd0: m_tvec = {a[31:2], 2'b00};
                2'd1: m_epc = {a[31:1], 1'b0};
                2'd2: m_cause = a;
                default: ;
            endcase
        end
    endtask

    // Read one machine register through a read micro-op into r7
    task automatic csr_read(input string tag, input logic [1:0] sel);
        step(tag, 1, 5'd7, 32'h40, 32'h0, {30'h0, sel}, 5'd0, F_SYS, 0, 2'd2, 0);
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : run
        m_tvec = 32'h100; m_epc = 32'h0; m_cause = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "rf_we in reset", 32'(rf_we), 32'h0);
        chk("R1", "redirect in reset", 32'(redirect_valid), 32'h0);
        rst_n = 1'b1;
        // R1 reset values read back
        csr_read("R1", 2'd0);
        csr_read("R1", 2'd1);
        csr_read("R1", 2'd2);
        // R2 results and the zero register
        step("R2", 1, 5'd5, 32'h200, 32'hDEAD_BEEF, 32'h0, 5'd0, F_ALU, 0, 2'd2, 0);
        step("R2", 1, 5'd0, 32'h204, 32'h1234_5678, 32'h0, 5'd0, F_ALU, 0, 2'd2, 0);
        step("R2", 1, 5'd9, 32'h208, 32'h0000_0042, 32'h0, 5'd0, F_MUL, 0, 2'd2, 0);
        // R3 load and store
        step("R3", 1, 5'd3, 32'h20C, 32'hCAFE_0001, 32'h0, 5'd0, F_MEM, 0, 2'd2, 0);
        step("R3", 1, 5'd3, 32'h210, 32'hCAFE_0002, 32'h0, 5'd1, F_MEM, 0, 2'd2, 0);
        // R10 swap vector base with unaligned data, then read it back
        step("R10", 1, 5'd4, 32'h214, 32'h0000_2003, 32'h0, 5'd1, F_SYS, 0, 2'd2, 0);
        csr_read("R10", 2'd0);
        csr_read("R10", 2'd3);
        // R4 links for both sizes, odd target
        step("R4", 1, 5'd1, 32'h300, 32'h0000_0801, 32'h0, 5'd0, F_JMP, 0, 2'd2, 0);
        step("R4", 1, 5'd1, 32'h302, 32'h0000_0900, 32'h0, 5'd0, F_JMP, 0, 2'd1, 0);
        step("R4", 1, 5'd0, 32'h304, 32'h0000_0A00, 32'h0, 5'd0, F_JMP, 0, 2'd2, 0);
        // R5 branch taken and not taken
        step("R5", 1, 5'd6, 32'h400, 32'h0000_0B01, 32'h1, 5'd1, F_JMP, 0, 2'd2, 0);
        step("R5", 1, 5'd6, 32'h404, 32'h0000_0C00, 32'h2, 5'd1, F_JMP, 0, 2'd2, 0);
        // R6 upstream trap, illegal-instruction cause 2
        step("R6", 1, 5'd8, 32'h500, 32'h1111_1111, 32'h2, 5'd0, F_ALU, 1, 2'd2, 0);
        csr_read("R6", 2'd1);
        csr_read("R6", 2'd2);
        // R7 local exceptions
        step("R7", 1, 5'd8, 32'h600, 32'h0, 32'h0, 5'd2, F_SYS, 0, 2'd2, 0);
        csr_read("R7", 2'd2);
        step("R7", 1, 5'd8, 32'h604, 32'h0, 32'h0, 5'd3, F_SYS, 0, 2'd2, 0);
        csr_read("R7", 2'd2);
        // R9 trap return uses the saved address
        step("R9", 1, 5'd2, 32'h608, 32'h0, 32'h0, 5'd4, F_SYS, 0, 2'd2, 0);
        // R8 interrupt on an ordinary word, then priority cases
        step("R8", 1, 5'd5, 32'h700, 32'h5555_5555, 32'h0, 5'd0, F_ALU, 0, 2'd2, 1);
        csr_read("R8", 2'd2);
        csr_read("R8", 2'd1);
        step("R8", 1, 5'd5, 32'h704, 32'h0, 32'h0, 5'd2, F_SYS, 0, 2'd2, 1);
        csr_read("R8", 2'd2);
        step("R8", 1, 5'd5, 32'h708, 32'h0, 32'h4, 5'd0, F_MEM, 1, 2'd2, 1);
        csr_read("R8", 2'd2);
        step("R8", 0, 5'd5, 32'h70C, 32'h7777_7777, 32'h0, 5'd0, F_ALU, 0, 2'd2, 1);
        csr_read("R8", 2'd1);
        // R10 swap of the saved address with odd data, then R9 return
        step("R10", 1, 5'd4, 32'h800, 32'h0000_3001, 32'h1, 5'd1, F_SYS, 0, 2'd2, 0);
        csr_read("R10", 2'd1);
        step("R9", 1, 5'd0, 32'h804, 32'h0, 32'h0, 5'd4, F_SYS, 0, 2'd2, 0);
        // R12 invalid words carrying trap, return and swap fields
        step("R12", 0, 5'd9, 32'h900, 32'hFFFF_FFFF, 32'h6, 5'd1, F_SYS, 1, 2'd2, 0);
        step("R12", 0, 5'd9, 32'h904, 32'hFFFF_FFF0, 32'h0, 5'd1, F_SYS, 0, 2'd2, 0);
        step("R12", 0, 5'd9, 32'h908, 32'h0, 32'h0, 5'd4, F_SYS, 0, 2'd2, 0);
        csr_read("R12", 2'd0);
        csr_read("R12", 2'd1);
        csr_read("R12", 2'd2);
        step("R12", 0, 5'd0, 32'h0, 32'h0, 32'h0, 5'd0, 8'h0, 0, 2'd2, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule